// File: doc/BRIEF.md
# Buffered ADC Trigger Comparator

This block raises analog-to-digital conversion start requests from a triangle-wave timer. Two channels, A and B, each own a 16-bit compare register. When the incoming counter value equals a channel's compare value, the block emits a single-cycle start request for that channel. It emits one pulse per match, however long the counter dwells on the value.

Software normally writes a pair of 16-bit shadow (buffer) registers. Their contents move into the live compare registers only when the counter turns around, at its crest or its trough. Because of this, a new trigger point never takes effect in the middle of a slope.

The register bus accepts only full-width accesses. A byte-qualified access leaves every register untouched and sets a sticky error flag. A global enable suppresses the request outputs, but it does not stop the turning-point transfers.

Top module: `adc_trig_cmp`

## Requirements
- R1: After reset, all four registers (compare A, compare B, buffer A, buffer B) hold 0xFFFF, both request outputs are 0, and the error flag is 0.
- R2: A full-width write with address 0, 1, 2 or 3 updates compare A, compare B, buffer A or buffer B respectively. A read presents that register on the read data port one cycle after the read strobe.
- R3: When the counter input equals compare A (or B) and the enable is high, request A (or B) is 1 in the cycle after the one in which the counter shows the value.
- R4: A request lasts exactly one cycle per match event. If the counter holds the matching value, no further pulse appears. After the counter leaves the value and returns to it, a new pulse is produced.
- R5: A one-cycle crest or trough strobe copies buffer A into compare A and buffer B into compare B on the clock edge where the strobe is sampled.
- R6: A buffer write in the same cycle as a crest or trough strobe is the value that gets transferred. A transfer takes priority over a direct compare write in the same cycle.
- R7: A write with the byte qualifier high changes no register. A read with the byte qualifier high returns 0. Either access sets the error flag, which stays set until reset.
- R8: While the enable is low, neither request output goes high, but crest and trough transfers still update the compare registers.
- R9: A buffer write without a crest or trough strobe does not change the compare registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Global request enable |
| cnt | input | 16 | Live timer counter value |
| crest | input | 1 | One-cycle strobe at the counter's upper turning point |
| trough | input | 1 | One-cycle strobe at the counter's lower turning point |
| bus_addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 buffer A, 3 buffer B |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_byte | input | 1 | High marks a byte-sized access, which is rejected |
| bus_rdata | output | 16 | Read data, valid one cycle after the read strobe |
| bus_err | output | 1 | Sticky flag for rejected byte accesses |
| req_a | output | 1 | Start request pulse for channel A |
| req_b | output | 1 | Start request pulse for channel B |

## Verification
The counter is first stepped onto a compare value and held there, then moved off and brought back. This separates a correct edge-detected pulse from a level output and from a request that cannot re-arm. Buffer writes are made with no strobe, with a crest strobe, and with a trough strobe in the same cycle as the write. These cases tell a properly deferred update apart from an immediate one, and show whether the fresh value or the stale buffer wins at the turning point. Byte-qualified writes and reads, together with a period with the enable low, show that rejected accesses and gated requests leave the registers and outputs as required while transfers continue.

// File: rtl/adc_trig_cmp.sv
module adc_trig_cmp #(
  parameter int W = 16,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] cnt,
  input  logic         crest,
  input  logic         trough,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  input  logic         bus_byte,
  output logic [W-1:0] bus_rdata,
  output logic         bus_err,
  output logic         req_a,
  output logic         req_b
);
  localparam logic [1:0] SEL_CMP_A = 2'd0;
  localparam logic [1:0] SEL_CMP_B = 2'd1;
  localparam logic [1:0] SEL_BUF_A = 2'd2;
  localparam logic [1:0] SEL_BUF_B = 2'd3;

  logic [W-1:0] cmp_a, cmp_b, buf_a, buf_b;
  logic [W-1:0] buf_a_nx, buf_b_nx;
  logic         hit_a, hit_b, hit_a_q, hit_b_q;
  logic         wr_ok, xfer;

  assign wr_ok    = bus_wr && !bus_byte;
  assign xfer     = crest || trough;
  assign buf_a_nx = (wr_ok && bus_addr == SEL_BUF_A) ? bus_wdata : buf_a;
  assign buf_b_nx = (wr_ok && bus_addr == SEL_BUF_B) ? bus_wdata : buf_b;
  assign hit_a    = (cnt == cmp_a);
  assign hit_b    = (cnt == cmp_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_a     <= INIT;
      cmp_b     <= INIT;
      buf_a     <= INIT;
      buf_b     <= INIT;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      hit_a_q   <= 1'b0;
      hit_b_q   <= 1'b0;
      req_a     <= 1'b0;
      req_b     <= 1'b0;
    end else begin
      buf_a <= buf_a_nx;
      buf_b <= buf_b_nx;
      if (xfer) begin
        cmp_a <= buf_a_nx;
        cmp_b <= buf_b_nx;
      end else begin
        if (wr_ok && bus_addr == SEL_CMP_A) cmp_a <= bus_wdata;
        if (wr_ok && bus_addr == SEL_CMP_B) cmp_b <= bus_wdata;
      end
      if (bus_byte && (bus_wr || bus_rd)) bus_err <= 1'b1;
      if (bus_rd) begin
        if (bus_byte) bus_rdata <= '0;
        else begin
          case (bus_addr)
            SEL_CMP_A: bus_rdata <= cmp_a;
            SEL_CMP_B: bus_rdata <= cmp_b;
            SEL_BUF_A: bus_rdata <= buf_a;
            default:   bus_rdata <= buf_b;
          endcase
        end
      end
      hit_a_q <= hit_a;
      hit_b_q <= hit_b;
      req_a   <= en && hit_a && !hit_a_q;
      req_b   <= en && hit_b && !hit_b_q;
    end
  end
endmodule

module adc_trig_cmp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic [W-1:0] cnt,
  input logic         crest,
  input logic         trough,
  input logic         bus_wr,
  input logic         bus_byte,
  input logic         bus_err,
  input logic         req_a,
  input logic         req_b,
  input logic [W-1:0] cmp_a,
  input logic [W-1:0] cmp_b,
  input logic [W-1:0] buf_a,
  input logic [W-1:0] buf_b
);
  AST_REQA_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_a |=> !req_a); // R4
  AST_REQB_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_b |=> !req_b); // R4
  AST_REQA_MATCH: assert property (@(posedge clk) disable iff (!rst_n) req_a |-> $past(cnt) == $past(cmp_a)); // R3
  AST_REQB_MATCH: assert property (@(posedge clk) disable iff (!rst_n) req_b |-> $past(cnt) == $past(cmp_b)); // R3
  AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n) !en |=> !(req_a || req_b)); // R8
  AST_XFER_A: assert property (@(posedge clk) disable iff (!rst_n) ((crest || trough) && !bus_wr) |=> cmp_a == $past(buf_a)); // R5
  AST_XFER_B: assert property (@(posedge clk) disable iff (!rst_n) ((crest || trough) && !bus_wr) |=> cmp_b == $past(buf_b)); // R5
  AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && bus_byte && !crest && !trough) |=> $stable(cmp_a) && $stable(cmp_b)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) bus_err |=> bus_err); // R7
endmodule

bind adc_trig_cmp adc_trig_cmp_chk #(.W(W)) u_chk (.*);

// File: tb/adc_trig_cmp_bench.sv
module adc_trig_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [15:0] cnt = '0;
  logic        crest = 1'b0, trough = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_byte = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err, req_a, req_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adc_trig_cmp u_adc_trig_cmp (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input bit byte_q);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_byte = byte_q;
    @(negedge clk);
    bus_wr = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input bit byte_q, output logic [15:0] d);
    bus_addr = a; bus_rd = 1'b1; bus_byte = byte_q;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0; bus_byte = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], 1'b0, d);
      chk("R1 reg init", d, 16'hFFFF);
    end
    chk("R1 req_a init", {15'd0, req_a}, 16'd0);
    chk("R1 req_b init", {15'd0, req_b}, 16'd0);
    chk("R1 err init", {15'd0, bus_err}, 16'd0);
  endtask

  task automatic t_rw();
    logic [15:0] d;
    wr(2'd0, 16'h1234, 1'b0);
    wr(2'd1, 16'h5678, 1'b0);
    wr(2'd2, 16'hAAAA, 1'b0);
    wr(2'd3, 16'h5555, 1'b0);
    rd(2'd0, 1'b0, d); chk("R2 cmp A", d, 16'h1234);
    rd(2'd1, 1'b0, d); chk("R2 cmp B", d, 16'h5678);
    rd(2'd2, 1'b0, d); chk("R2 buf A", d, 16'hAAAA);
    rd(2'd3, 1'b0, d); chk("R2 buf B", d, 16'h5555);
  endtask

  task automatic t_xfer();
    logic [15:0] d;
    wr(2'd2, 16'h0010, 1'b0);
    wr(2'd3, 16'h0020, 1'b0);
    rd(2'd0, 1'b0, d); chk("R9 cmp A held", d, 16'h1234);
    rd(2'd1, 1'b0, d); chk("R9 cmp B held", d, 16'h5678);
    crest = 1'b1; @(negedge clk); crest = 1'b0;
    rd(2'd0, 1'b0, d); chk("R5 crest A", d, 16'h0010);
    rd(2'd1, 1'b0, d); chk("R5 crest B", d, 16'h0020);
  endtask

  task automatic t_match();
    cnt = 16'h0010; @(negedge clk);
    chk("R3 req_a hit", {15'd0, req_a}, 16'd1);
    chk("R3 req_b quiet", {15'd0, req_b}, 16'd0);
    @(negedge clk);
    chk("R4 held no repeat", {15'd0, req_a}, 16'd0);
    cnt = 16'h0020; @(negedge clk);
    chk("R3 req_b hit", {15'd0, req_b}, 16'd1);
    cnt = 16'h0011; @(negedge clk);
    cnt = 16'h0010; @(negedge clk);
    chk("R4 rearm", {15'd0, req_a}, 16'd1);
    cnt = 16'h0000; @(negedge clk);
  endtask

  task automatic t_same();
    logic [15:0] d;
    trough = 1'b1;
    wr(2'd2, 16'h0030, 1'b0);
    trough = 1'b0;
    rd(2'd0, 1'b0, d); chk("R6 same-cycle value", d, 16'h0030);
    crest = 1'b1;
    wr(2'd1, 16'h7777, 1'b0);
    crest = 1'b0;
    rd(2'd1, 1'b0, d); chk("R6 transfer over direct", d, 16'h0020);
  endtask

  task automatic t_byte();
    logic [15:0] d;
    wr(2'd0, 16'hBEEF, 1'b1);
    chk("R7 err set", {15'd0, bus_err}, 16'd1);
    rd(2'd0, 1'b0, d); chk("R7 write ignored", d, 16'h0030);
    rd(2'd0, 1'b1, d); chk("R7 byte read zero", d, 16'h0000);
    @(negedge clk);
    chk("R7 err sticky", {15'd0, bus_err}, 16'd1);
  endtask

  task automatic t_en();
    logic [15:0] d;
    en = 1'b0;
    cnt = 16'h0030; @(negedge clk);
    chk("R8 gated req_a", {15'd0, req_a}, 16'd0);
    wr(2'd2, 16'h0040, 1'b0);
    crest = 1'b1; @(negedge clk); crest = 1'b0;
    rd(2'd0, 1'b0, d); chk("R8 transfer while off", d, 16'h0040);
    en = 1'b1;
    cnt = 16'h0040; @(negedge clk);
    chk("R8 req after enable", {15'd0, req_a}, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rw();
    t_xfer();
    t_match();
    t_same();
    t_byte();
    t_en();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule